// File: doc/BRIEF.md
# Reversible 5/3 Lifting Wavelet Line Engine

The block applies a one-dimensional integer 5/3 lifting wavelet to one line of signed samples at a time. Samples arrive on a valid/ready stream that carries start-of-line and end-of-line flags. The line is held in a small register array. Two in-place passes run over it, one element per cycle: a predict pass on the odd positions and an update pass on the even positions. The result then leaves in position order, one coefficient per cycle, with a band tag and a last flag. Every division is an arithmetic right shift, so the block needs no multiplier. The integer rounding makes the transform exactly reversible.

A mode bit chooses the forward transform (predict, then update) or the inverse transform (un-update, then un-predict with the opposite signs). Both directions use the same neighbour adder, shifter and add/subtract unit. Symmetric mirroring at the line ends costs no padded copy. It is done by steering the neighbour read addresses with multiplexers at the first and last positions. Outputs are two bits wider than inputs, which covers the growth of both directions.

Top module: `lift53_wavelet`

## Requirements
- R1: In forward mode, each odd output position 2n+1 carries d = x[2n+1] - floor((x[2n] + x[2n+2]) / 2).
- R2: In forward mode, each even output position 2n carries s = x[2n] + floor((d[n-1] + d[n] + 2) / 4).
- R3: At the line ends the data are mirrored. A missing right even neighbour x[N] is replaced by x[N-2]. A missing left detail d[-1] is replaced by d[0]. For odd N, the missing right detail of the last even position is replaced by the detail on its left.
- R4: In inverse mode, with s at even positions and d at odd positions, even outputs are s - floor((dl + dr + 2) / 4) and odd outputs are d + floor((xl + xr) / 2). The same mirroring applies. A forward line fed back through the inverse reproduces the original samples exactly.
- R5: The N results leave on consecutive cycles in position order 0..N-1. out_band equals the position parity (0 = even/low, 1 = odd/high). out_last is high only on position N-1.
- R6: out_data is IW+2 bits, two's complement. No result overflows for any IW-bit input, full-scale extremes included.
- R7: A line closes on a beat with in_eol, or on the MAX_LEN-th sample when in_eol never arrives.
- R8: A beat with in_sol becomes position 0 of a new line. Samples of an unfinished earlier line are discarded and never emitted.
- R9: inv_mode is sampled with the position-0 sample. Changes on later beats of the same line have no effect.
- R10: A line closed after a single sample is emitted unchanged with out_band 0 and out_last 1, in either mode.
- R11: After reset, out_valid is 0 and in_ready is 1. in_ready stays low from the close of a line until the cycle after its last output, so no sample is accepted while results are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | IW | Signed input sample (or coefficient in inverse mode) |
| in_sol | input | 1 | Beat is position 0 of a new line |
| in_eol | input | 1 | Beat is the last of the line |
| inv_mode | input | 1 | 0 = forward, 1 = inverse; sampled at position 0 |
| out_valid | output | 1 | Output result present |
| out_data | output | IW+2 | Signed output coefficient or sample |
| out_band | output | 1 | Position parity: 0 even/low, 1 odd/high |
| out_last | output | 1 | Final result of the line |

## Verification
The forward transform is swept over every line length from 2 to MAX_LEN with ramps, alternating signs, constants, full-scale extremes and pseudo-random data. Lengths 2 and 3 are also run exhaustively over a set of edge values. Ramps and constants expose a wrong predict sign or rounding. Alternating data separate left from right mirroring. The extremes expose overflow and floor versus truncation. Inverse lines are checked against an arithmetic model with random full-range coefficients and also by forward-then-inverse round trips. Further lines cover the length cap, a restart mid-line, mode toggling mid-line and the one-sample line.

// File: rtl/lift53_pkg.sv
package lift53_pkg;

    // Line phases: collect samples, two in-place lifting passes, emit results.
    typedef enum logic [1:0] {
        PH_FILL  = 2'd0,
        PH_PASS1 = 2'd1,
        PH_PASS2 = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

endpackage

// File: rtl/lift53_step.sv
// Shared lifting arithmetic: one neighbour sum, one shift, one add/subtract.
// Predict: delta = floor((a+b)/2). Update: delta = floor((a+b+2)/4).
// The sign of the correction depends on step kind and direction.
module lift53_step #(
    parameter int OW = 10
) (
    input  logic signed [OW-1:0] ctr,
    input  logic signed [OW-1:0] nb_a,
    input  logic signed [OW-1:0] nb_b,
    input  logic                 upd,
    input  logic                 inv,
    output logic signed [OW-1:0] res
);
    localparam int SW = OW + 2;

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] shifted;
    logic signed [OW-1:0] delta;
    logic                 sub;

    always_comb begin
        sum     = {{2{nb_a[OW-1]}}, nb_a} + {{2{nb_b[OW-1]}}, nb_b}
                  + (upd ? SW'(2) : SW'(0));
        shifted = upd ? (sum >>> 2) : (sum >>> 1);
        delta   = shifted[OW-1:0];
        // forward predict and inverse update subtract; the other two add
        sub     = (upd == inv);
        res     = sub ? (ctr - delta) : (ctr + delta);
    end

endmodule

// File: rtl/lift53_line_buf.sv
// Line storage: one write port, three read ports (centre and two neighbours).
module lift53_line_buf #(
    parameter int OW    = 10,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [OW-1:0] wr_data,
    input  logic [AW-1:0] rd_c,
    input  logic [AW-1:0] rd_l,
    input  logic [AW-1:0] rd_r,
    output logic [OW-1:0] q_c,
    output logic [OW-1:0] q_l,
    output logic [OW-1:0] q_r
);
    logic [OW-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (wr_en && (wr_addr == AW'(e))) begin
                mem[e] <= wr_data;
            end
        end
    end

    assign q_c = mem[rd_c];
    assign q_l = mem[rd_l];
    assign q_r = mem[rd_r];

endmodule

// File: rtl/lift53_ctrl.sv
// Sequencer: collects the line, walks the two passes with mirrored neighbour
// addressing, then drains the results in position order.
module lift53_ctrl
    import lift53_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LW     = $clog2(MAX_LEN + 1),
    localparam int AW     = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic          in_eol,
    input  logic          inv_mode,
    output logic          in_ready,
    output logic          wr_en,
    output logic          wr_fill,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_c,
    output logic [AW-1:0] rd_l,
    output logic [AW-1:0] rd_r,
    output logic          step_upd,
    output logic          step_inv,
    output logic          out_valid,
    output logic          out_band,
    output logic          out_last
);
    typedef struct packed {
        phase_e        phase;
        logic [LW-1:0] cnt;
        logic [LW-1:0] len;
        logic [LW-1:0] idx;
        logic          inv;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [LW-1:0] pos;
    logic [LW-1:0] nxt_cnt;
    logic [LW-1:0] idx_p1;
    logic [LW-1:0] idx_m1;
    logic [LW:0]   idx_p2;
    logic [LW-1:0] wr_pos;
    logic [LW-1:0] l_pos;
    logic [LW-1:0] r_pos;
    logic          inv_eff;
    logic          pass_done;

    always_comb begin
        st_d      = st_q;
        in_ready  = 1'b0;
        wr_en     = 1'b0;
        wr_fill   = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;

        pos       = in_sol ? '0 : st_q.cnt;
        nxt_cnt   = pos + 1'b1;
        inv_eff   = (pos == '0) ? inv_mode : st_q.inv;
        idx_p1    = st_q.idx + 1'b1;
        idx_m1    = st_q.idx - 1'b1;
        idx_p2    = {1'b0, st_q.idx} + (LW+1)'(2);
        pass_done = (idx_p2 >= {1'b0, st_q.len});
        step_upd  = (st_q.phase == PH_PASS1) ? st_q.inv : ~st_q.inv;
        step_inv  = st_q.inv;
        wr_pos    = st_q.idx;

        // mirrored neighbours: position 0 looks right twice, the last
        // position looks left twice
        l_pos     = (st_q.idx == '0) ? idx_p1 : idx_m1;
        r_pos     = (idx_p1 < st_q.len) ? idx_p1 : idx_m1;

        case (st_q.phase)
            PH_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    wr_en   = 1'b1;
                    wr_fill = 1'b1;
                    wr_pos  = pos;
                    st_d.inv = inv_eff;
                    if (in_eol || (nxt_cnt == LW'(MAX_LEN))) begin
                        st_d.len = nxt_cnt;
                        st_d.cnt = '0;
                        if (nxt_cnt == LW'(1)) begin
                            st_d.phase = PH_DRAIN;
                            st_d.idx   = '0;
                        end else begin
                            st_d.phase = PH_PASS1;
                            st_d.idx   = inv_eff ? LW'(0) : LW'(1);
                        end
                    end else begin
                        st_d.cnt = nxt_cnt;
                    end
                end
            end
            PH_PASS1, PH_PASS2: begin
                wr_en = 1'b1;
                if (pass_done) begin
                    if (st_q.phase == PH_PASS1) begin
                        st_d.phase = PH_PASS2;
                        st_d.idx   = step_upd ? LW'(1) : LW'(0);
                    end else begin
                        st_d.phase = PH_DRAIN;
                        st_d.idx   = '0;
                    end
                end else begin
                    st_d.idx = idx_p2[LW-1:0];
                end
            end
            PH_DRAIN: begin
                out_valid = 1'b1;
                out_last  = (idx_p1 == st_q.len);
                if (out_last) begin
                    st_d.phase = PH_FILL;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx = idx_p1;
                end
            end
            default: st_d.phase = PH_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_FILL, cnt: '0, len: '0, idx: '0, inv: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr  = wr_pos[AW-1:0];
    assign rd_c     = st_q.idx[AW-1:0];
    assign rd_l     = l_pos[AW-1:0];
    assign rd_r     = r_pos[AW-1:0];
    assign out_band = st_q.idx[0];

endmodule

// File: rtl/lift53_wavelet.sv
// Top: reversible 5/3 lifting wavelet on one line at a time.
module lift53_wavelet #(
    parameter int IW      = 8,
    parameter int MAX_LEN = 16,
    localparam int OW     = IW + 2,
    localparam int AW     = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [IW-1:0] in_data,
    input  logic          in_sol,
    input  logic          in_eol,
    input  logic          inv_mode,
    output logic          out_valid,
    output logic [OW-1:0] out_data,
    output logic          out_band,
    output logic          out_last
);
    logic          wr_en;
    logic          wr_fill;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_c;
    logic [AW-1:0] rd_l;
    logic [AW-1:0] rd_r;
    logic          step_upd;
    logic          step_inv;
    logic [OW-1:0] q_c;
    logic [OW-1:0] q_l;
    logic [OW-1:0] q_r;
    logic [OW-1:0] step_res;
    logic [OW-1:0] wr_data;

    lift53_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_eol   (in_eol),
        .inv_mode (inv_mode),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_fill  (wr_fill),
        .wr_addr  (wr_addr),
        .rd_c     (rd_c),
        .rd_l     (rd_l),
        .rd_r     (rd_r),
        .step_upd (step_upd),
        .step_inv (step_inv),
        .out_valid(out_valid),
        .out_band (out_band),
        .out_last (out_last)
    );

    lift53_line_buf #(.OW(OW), .DEPTH(MAX_LEN)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_c   (rd_c),
        .rd_l   (rd_l),
        .rd_r   (rd_r),
        .q_c    (q_c),
        .q_l    (q_l),
        .q_r    (q_r)
    );

    lift53_step #(.OW(OW)) u_step (
        .ctr (q_c),
        .nb_a(q_l),
        .nb_b(q_r),
        .upd (step_upd),
        .inv (step_inv),
        .res (step_res)
    );

    assign wr_data  = wr_fill ? {{2{in_data[IW-1]}}, in_data} : step_res;
    assign out_data = q_c;

endmodule

// File: rtl/lift53_wavelet_chk.sv
// Protocol checker, bound to the top.
module lift53_wavelet_chk #(
    parameter int MAX_LEN = 16
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic out_valid,
    input logic out_band,
    input logic out_last
);
    logic [31:0] ocnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocnt <= '0;
        end else if (out_valid) begin
            ocnt <= out_last ? '0 : ocnt + 32'd1;
        end
    end

    // R11: no sample accepted while results are being emitted
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R11: the cycle after the last result, the block is idle and ready again
    a_r11_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> (!out_valid && in_ready));

    // R5: last flag only on a valid beat
    a_r5_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R5: band tag alternates within a burst
    a_r5_band_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(out_last)) |-> (out_band != $past(out_band)));

    // R5: every burst starts at an even position
    a_r5_first_band_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> !out_band);

    // R7: never more than MAX_LEN results per line
    a_r7_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ocnt < MAX_LEN));

endmodule

bind lift53_wavelet lift53_wavelet_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_band (out_band),
    .out_last (out_last)
);

// File: tb/lift53_wavelet_tb.sv
`timescale 1ns/1ps
module lift53_wavelet_tb;
    localparam int IW      = 8;
    localparam int MAX_LEN = 8;
    localparam int OW      = IW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] in_data = '0;
    logic          in_sol = 1'b0;
    logic          in_eol = 1'b0;
    logic          inv_mode = 1'b0;
    logic          out_valid;
    logic [OW-1:0] out_data;
    logic          out_band;
    logic          out_last;

    always #4 clk = ~clk;

    lift53_wavelet #(.IW(IW), .MAX_LEN(MAX_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sol(in_sol), .in_eol(in_eol), .inv_mode(inv_mode),
        .out_valid(out_valid), .out_data(out_data), .out_band(out_band),
        .out_last(out_last)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    int stim [16];
    int expv [16];
    int got  [32];
    bit gband [32];
    bit glast [32];
    bit gbusy [32];
    int gcnt = 0;
    int rng = 32'h1234_5678;

    // capture results away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (gcnt < 32) begin
                got[gcnt]   = $signed(out_data);
                gband[gcnt] = out_band;
                glast[gcnt] = out_last;
                gbusy[gcnt] = in_ready;
            end
            gcnt = gcnt + 1;
        end
    end

    function automatic int next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >>> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // forward reference: details from samples, then smooth values
    function automatic void fwd_model(input int n);
        int d [16];
        for (int i = 1; i < n; i += 2) begin
            int rt = (i + 1 < n) ? stim[i+1] : stim[i-1];
            d[i] = stim[i] - ((stim[i-1] + rt) >>> 1);
            expv[i] = d[i];
        end
        for (int i = 0; i < n; i += 2) begin
            if (n == 1) begin
                expv[i] = stim[i];
            end else begin
                int lt = (i > 0) ? d[i-1] : d[i+1];
                int rt = (i + 1 < n) ? d[i+1] : d[i-1];
                expv[i] = stim[i] + ((lt + rt + 2) >>> 2);
            end
        end
    endfunction

    // inverse reference: even samples first, then odd samples
    function automatic void inv_model(input int n);
        for (int i = 0; i < n; i += 2) begin
            if (n == 1) begin
                expv[i] = stim[i];
            end else begin
                int lt = (i > 0) ? stim[i-1] : stim[i+1];
                int rt = (i + 1 < n) ? stim[i+1] : stim[i-1];
                expv[i] = stim[i] - ((lt + rt + 2) >>> 2);
            end
        end
        for (int i = 1; i < n; i += 2) begin
            int rt = (i + 1 < n) ? expv[i+1] : expv[i-1];
            expv[i] = stim[i] + ((expv[i-1] + rt) >>> 1);
        end
    endfunction

    task automatic drive(input int n, input bit invm, input bit close, input bit flip);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data  = stim[i][IW-1:0];
            in_sol   = (i == 0);
            in_eol   = close && (i == n - 1);
            inv_mode = invm ^ (flip && (i > 0));
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_eol   = 1'b0;
    endtask

    task automatic collect(input int n, input string tag);
        int t = 0;
        while (gcnt < n && t < 400) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        nchk++;
        if (gcnt != n) begin
            nfail++;
            $display("FAIL %s result count: actual %0d expected %0d", tag, gcnt, n);
        end
        for (int i = 0; i < n && i < gcnt; i++) begin
            nchk++;
            if (got[i] != expv[i] || gband[i] != i[0] || glast[i] != (i == n - 1)
                || gbusy[i]) begin
                nfail++;
                $display("FAIL %s pos %0d: actual data=%0d band=%0d last=%0d ready=%0d expected data=%0d band=%0d last=%0d ready=0",
                         tag, i, got[i], gband[i], glast[i], gbusy[i],
                         expv[i], i[0], (i == n - 1));
            end
        end
    endtask

    task automatic run_fwd(input int n, input string tag);
        fwd_model(n);
        gcnt = 0;
        drive(n, 1'b0, 1'b1, 1'b0);
        collect(n, tag);
    endtask

    task automatic run_inv(input int n, input string tag);
        inv_model(n);
        gcnt = 0;
        drive(n, 1'b1, 1'b1, 1'b0);
        collect(n, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int vals [7];
        int orig [16];
        vals = '{-128, -127, -1, 0, 1, 126, 127};

        repeat (3) @(negedge clk);
        // R11: reset state
        nchk++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            nfail++;
            $display("FAIL R11 reset: actual valid=%0b ready=%0b expected valid=0 ready=1",
                     out_valid, in_ready);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1/R2/R3: every length, several patterns
        for (int n = 2; n <= MAX_LEN; n++) begin
            for (int i = 0; i < n; i++) stim[i] = 3 * i - 10;
            run_fwd(n, "R1/R2/R3 ramp");
            for (int i = 0; i < n; i++) stim[i] = i[0] ? -50 : 60;
            run_fwd(n, "R1/R2/R3 alternating");
            for (int i = 0; i < n; i++) stim[i] = -7;
            run_fwd(n, "R1/R2 constant");
            for (int i = 0; i < n; i++) stim[i] = i[0] ? 127 : -128;
            run_fwd(n, "R6 extremes");
            for (int i = 0; i < n; i++) stim[i] = i[0] ? -128 : 127;
            run_fwd(n, "R6 extremes swapped");
            for (int k = 0; k < 6; k++) begin
                for (int i = 0; i < n; i++) stim[i] = $signed(next_rand() & 32'hFF) - 128;
                run_fwd(n, "R1/R2/R3 random");
            end
        end

        // R3/R6: exhaustive short lines over edge values
        for (int a = 0; a < 7; a++)
            for (int b = 0; b < 7; b++) begin
                stim[0] = vals[a]; stim[1] = vals[b];
                run_fwd(2, "R3/R6 exhaustive len2");
            end
        for (int a = 0; a < 7; a++)
            for (int b = 0; b < 7; b++)
                for (int c = 0; c < 7; c++) begin
                    stim[0] = vals[a]; stim[1] = vals[b]; stim[2] = vals[c];
                    run_fwd(3, "R3/R6 exhaustive len3");
                end

        // R4: inverse against the arithmetic model, full-range coefficients
        for (int n = 2; n <= MAX_LEN; n++) begin
            for (int k = 0; k < 6; k++) begin
                for (int i = 0; i < n; i++) stim[i] = $signed(next_rand() & 32'hFF) - 128;
                run_inv(n, "R4 inverse");
            end
            for (int i = 0; i < n; i++) stim[i] = i[0] ? -128 : 127;
            run_inv(n, "R4/R6 inverse extremes");
        end

        // R4: forward then inverse gives back the samples
        for (int n = 2; n <= MAX_LEN; n++) begin
            for (int k = 0; k < 4; k++) begin
                for (int i = 0; i < n; i++) begin
                    stim[i] = $signed(next_rand() & 32'h3F) - 32;
                    orig[i] = stim[i];
                end
                run_fwd(n, "R4 round trip forward");
                for (int i = 0; i < n; i++) stim[i] = got[i];
                gcnt = 0;
                for (int i = 0; i < n; i++) expv[i] = orig[i];
                drive(n, 1'b1, 1'b1, 1'b0);
                collect(n, "R4 round trip inverse");
            end
        end

        // R7: line closes by itself at MAX_LEN samples
        for (int i = 0; i < MAX_LEN; i++) stim[i] = 11 * i - 40;
        fwd_model(MAX_LEN);
        gcnt = 0;
        drive(MAX_LEN, 1'b0, 1'b0, 1'b0);
        collect(MAX_LEN, "R7 length cap");

        // R8: unfinished line is dropped when a new line starts
        for (int i = 0; i < 3; i++) stim[i] = 100 - i;
        gcnt = 0;
        drive(3, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        nchk++;
        if (gcnt != 0) begin
            nfail++;
            $display("FAIL R8 partial line: actual %0d results expected 0", gcnt);
        end
        for (int i = 0; i < 5; i++) stim[i] = 5 * i - 9;
        run_fwd(5, "R8 restart");

        // R9: mode toggled after position 0 is ignored
        for (int i = 0; i < 6; i++) stim[i] = (i * i) - 12;
        fwd_model(6);
        gcnt = 0;
        drive(6, 1'b0, 1'b1, 1'b1);
        collect(6, "R9 forward held");
        inv_model(6);
        gcnt = 0;
        drive(6, 1'b1, 1'b1, 1'b1);
        collect(6, "R9 inverse held");

        // R10: one-sample lines pass unchanged
        stim[0] = 77;
        run_fwd(1, "R10 single forward");
        stim[0] = -128;
        run_inv(1, "R10 single inverse");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule